// File: doc/BRIEF.md
# Event-Triggered Transfer Sequencer

This block is a small transfer engine that wakes on a peripheral event. An event carries a vector index. The engine reads a 16-bit vector word from a table and uses it as the address of a transfer descriptor in on-chip RAM. It loads the descriptor, moves data in normal, repeat or block mode, and writes the updated descriptor back. A set chain flag sends it on to the next descriptor in the same activation. Three internal bookkeeping states close every activation.

The engine is the only master on a simple memory bus. Each access holds `mem_req` with a stable address, size, direction and write data for a number of states. That number depends only on the address region and the access size, so the state count of every activation can be predicted exactly. Read data is taken in the last state of an access.

The event input is a valid/ready stream. `evt_ready` is high only while the engine is idle. A source holds `evt_valid` and `evt_vec` until a cycle in which both valid and ready are high, and that cycle accepts the event. No event is queued while the engine is busy, so back-pressure simply lasts for one activation.

Top module: `evt_xfer_seq`

## Requirements
- R1: `evt_ready` equals not `busy`. An event accepted on a clock edge starts the vector read in the next cycle, and `busy` stays high for every state of the activation and no longer.
- R2: The vector is a word read at `VEC_BASE + 2*evt_vec`. Its 16 bits give the address of the first descriptor.
- R3: A descriptor is three 32-bit words at offsets +0, +4 and +8. Word0 holds the source address in bits 31:16 and the destination address in 15:0. Word1 holds the mode in 31:30 (0 normal, 1 repeat, 2 block, 3 acts as normal), the data width in 29 (1 = 16-bit, 0 = byte), the source step in 28:27, the destination step in 26:25, the chain flag in 24, the side select in 23 (1 source, 0 destination), the reload/block size in 15:8 and the count in 7:0. Word2 holds the restore address in 15:0. Each descriptor is read as three long accesses before its data moves and written back as three long accesses after it.
- R4: Address bits 15:14 select the region: 0 ROM, 1 RAM, 2 I/O on a 16-bit port, 3 I/O on an 8-bit port. ROM and RAM accesses take 1 state. A byte I/O access takes 2 states. A 16-bit I/O access takes 2 states on the 16-bit port and 4 states on the 8-bit port.
- R5: Normal mode moves one item per descriptor and decrements the count. When the count goes from 1 to 0, a completion interrupt is due.
- R6: Repeat mode moves one item and decrements the count. When the count was 1, the count is reloaded from the reload field and the side address is set to the restore address.
- R7: Block mode moves N items, where N is the reload field, then decrements the count and sets the side address to the restore address. A count going from 1 to 0 makes an interrupt due.
- R8: After each data access, the address used steps by the data width when its step code is 1, steps down by the width when it is 2, and holds for 0 or 3. Each data item is written unchanged to the destination.
- R9: When the chain flag is set, the next descriptor, 12 bytes further on, is processed in the same activation without a further vector read.
- R10: `state_cnt` clears on acceptance and counts every busy state. When the activation ends it equals `Cvec + sum over descriptors of (6 + N*(Csrc+Cdst)) + 3`, and it holds that value until the next acceptance.
- R11: `done_irq` pulses for one cycle, in the first idle cycle after an activation in which any descriptor made an interrupt due.
- R12: After reset the block is idle: `busy`, `mem_req` and `done_irq` are low, `evt_ready` is high and `state_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event request |
| evt_ready | output | 1 | Engine can accept an event |
| evt_vec | input | VEC_W | Vector index of the event |
| busy | output | 1 | Activation in progress |
| state_cnt | output | CNT_W | States spent in the current or last activation |
| done_irq | output | 1 | One-cycle completion interrupt |
| mem_req | output | 1 | Bus access in progress, held for its whole length |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 2 | 0 byte, 1 word, 2 long |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_rdata | input | 32 | Read data, low-aligned, taken in the last state of a read |

## Verification
An event accepted on one edge makes `busy` high from the next cycle. All results of the activation (the final `state_cnt`, the written-back descriptors, the moved data and `done_irq`) are due in the first cycle in which `busy` is low again. That cycle comes exactly Cvec + Σ(6 + N·(Csrc+Csink)) + 3 cycles after acceptance. The bench samples every signal on falling edges and performs bus writes in its memory model in the same falling-edge loop. It counts the busy cycles itself and checks that count, the counter, the interrupt and the memory contents only in that first idle cycle. It then compares them with values computed from the region costs and the descriptor fields it wrote.

// File: rtl/evt_xfer_pkg.sv
package evt_xfer_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  typedef logic [ADDR_W-1:0] xaddr_t;

  // bus access sizes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // region tags in address bits 15:14
  localparam logic [1:0] RG_ROM  = 2'd0;
  localparam logic [1:0] RG_RAM  = 2'd1;
  localparam logic [1:0] RG_IO16 = 2'd2;
  localparam logic [1:0] RG_IO8  = 2'd3;

  // transfer modes
  localparam logic [1:0] XM_NORMAL = 2'd0;
  localparam logic [1:0] XM_REPEAT = 2'd1;
  localparam logic [1:0] XM_BLOCK  = 2'd2;

  // address step codes
  localparam logic [1:0] STEP_UP = 2'b01;
  localparam logic [1:0] STEP_DN = 2'b10;

  // descriptor geometry
  localparam int DESC_WORDS = 3;
  localparam int DESC_BYTES = 4 * DESC_WORDS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VEC,
    ST_DRD,
    ST_XRD,
    ST_XWR,
    ST_DWR,
    ST_INT
  } xs_state_t;

  typedef struct packed {
    logic [1:0] mode;
    logic       wide;
    logic [1:0] sstep;
    logic [1:0] dstep;
    logic       chain;
  } xd_ctl_t;

endpackage

// File: rtl/evt_xfer_cost.sv
module evt_xfer_cost
  import evt_xfer_pkg::*;
#(
  parameter int COST_MEM    = 1,
  parameter int COST_IO_B   = 2,
  parameter int COST_IO16_W = 2,
  parameter int COST_IO8_W  = 4,
  parameter int CW          = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [CW-1:0]     cost
);

  logic [1:0] region;
  assign region = addr[ADDR_W-1 -: 2];

  // per-port word cost; a long access on an I/O port is two words
  function automatic logic [CW-1:0] io_cost(input logic [1:0] sz, input int wcost);
    logic [CW-1:0] r;
    case (sz)
      SZ_BYTE: r = CW'(COST_IO_B);
      SZ_WORD: r = CW'(wcost);
      default: r = CW'(2 * wcost);
    endcase
    return r;
  endfunction

  always_comb begin
    case (region)
      RG_IO16: cost = io_cost(size, COST_IO16_W);
      RG_IO8:  cost = io_cost(size, COST_IO8_W);
      default: cost = CW'(COST_MEM);
    endcase
  end

endmodule

// File: rtl/evt_xfer_stcnt.sv
module evt_xfer_stcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl
  import evt_xfer_pkg::*;
#(
  parameter int          VEC_W    = 4,
  parameter int          CW       = 4,
  parameter int          INT_N    = 3,
  parameter logic [15:0] VEC_BASE = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [VEC_W-1:0]  evt_vec,
  output logic              evt_ready,
  output logic              start,
  output logic              busy,
  output logic              done_irq,
  input  logic [CW-1:0]     acc_cost,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int IW = (INT_N > (1 << CW)) ? $clog2(INT_N) : CW;

  xs_state_t        state_q;
  logic [1:0]       idx_q;
  logic [IW-1:0]    wcnt_q;
  logic [VEC_W-1:0] vec_q;
  xaddr_t           dptr_q, src_q, dst_q, init_q;
  xd_ctl_t          ctl_q;
  logic             side_q;
  logic [7:0]       rel_q, cur_q, left_q;
  logic [15:0]      data_q;
  logic             hit_q, irq_q;

  logic             fin;
  logic [IW-1:0]    lim;
  logic             last_pair;
  logic             is_block, is_rep;
  xaddr_t           desc_addr;
  logic             unused_rd;

  assign unused_rd = ^mem_rdata[22:16];

  function automatic xaddr_t nstep(input xaddr_t a, input logic [1:0] sel, input logic wide);
    xaddr_t d;
    d = wide ? xaddr_t'(2) : xaddr_t'(1);
    case (sel)
      STEP_UP: return a + d;
      STEP_DN: return a - d;
      default: return a;
    endcase
  endfunction

  assign busy      = (state_q != ST_IDLE);
  assign evt_ready = !busy;
  assign start     = evt_ready && evt_valid;
  assign done_irq  = irq_q;
  assign is_block  = (ctl_q.mode == XM_BLOCK);
  assign is_rep    = (ctl_q.mode == XM_REPEAT);
  assign last_pair = (left_q == 8'd1);
  assign desc_addr = dptr_q + xaddr_t'({idx_q, 2'b00});

  // bus drive, decoded from the state registers only
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_size  = SZ_LONG;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state_q)
      ST_VEC: begin
        mem_req  = 1'b1;
        mem_size = SZ_WORD;
        mem_addr = VEC_BASE + xaddr_t'({vec_q, 1'b0});
      end
      ST_DRD: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr;
      end
      ST_XRD: begin
        mem_req  = 1'b1;
        mem_size = ctl_q.wide ? SZ_WORD : SZ_BYTE;
        mem_addr = src_q;
      end
      ST_XWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_size  = ctl_q.wide ? SZ_WORD : SZ_BYTE;
        mem_addr  = dst_q;
        mem_wdata = {16'h0000, data_q};
      end
      ST_DWR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = desc_addr;
        case (idx_q)
          2'd0:    mem_wdata = {src_q, dst_q};
          2'd1:    mem_wdata = {ctl_q, side_q, 7'h00, rel_q, cur_q};
          default: mem_wdata = {16'h0000, init_q};
        endcase
      end
      default: ;
    endcase
  end

  // one busy cycle is one state; an access ends when its cost is used up
  always_comb begin
    if (state_q == ST_INT) lim = IW'(INT_N - 1);
    else                   lim = IW'(acc_cost) - 1'b1;
    fin = busy && (wcnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
      vec_q   <= '0;
      dptr_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      init_q  <= '0;
      ctl_q   <= '0;
      side_q  <= 1'b0;
      rel_q   <= '0;
      cur_q   <= '0;
      left_q  <= '0;
      data_q  <= '0;
      hit_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (busy) wcnt_q <= fin ? '0 : wcnt_q + 1'b1;

      case (state_q)
        ST_IDLE: begin
          if (start) begin
            vec_q   <= evt_vec;
            hit_q   <= 1'b0;
            wcnt_q  <= '0;
            state_q <= ST_VEC;
          end
        end

        ST_VEC: if (fin) begin
          dptr_q  <= mem_rdata[15:0];
          idx_q   <= 2'd0;
          state_q <= ST_DRD;
        end

        ST_DRD: if (fin) begin
          case (idx_q)
            2'd0: begin
              src_q <= mem_rdata[31:16];
              dst_q <= mem_rdata[15:0];
              idx_q <= 2'd1;
            end
            2'd1: begin
              ctl_q  <= xd_ctl_t'(mem_rdata[31:24]);
              side_q <= mem_rdata[23];
              rel_q  <= mem_rdata[15:8];
              cur_q  <= mem_rdata[7:0];
              idx_q  <= 2'd2;
            end
            default: begin
              init_q  <= mem_rdata[15:0];
              left_q  <= is_block ? rel_q : 8'd1;
              idx_q   <= 2'd0;
              state_q <= ST_XRD;
            end
          endcase
        end

        ST_XRD: if (fin) begin
          data_q  <= ctl_q.wide ? mem_rdata[15:0] : {8'h00, mem_rdata[7:0]};
          src_q   <= nstep(src_q, ctl_q.sstep, ctl_q.wide);
          state_q <= ST_XWR;
        end

        ST_XWR: if (fin) begin
          dst_q  <= nstep(dst_q, ctl_q.dstep, ctl_q.wide);
          left_q <= left_q - 1'b1;
          if (last_pair) begin
            state_q <= ST_DWR;
            idx_q   <= 2'd0;
            if (is_rep) begin
              if (cur_q == 8'd1) begin
                cur_q <= rel_q;
                if (side_q) src_q <= init_q;
                else        dst_q <= init_q;
              end else begin
                cur_q <= cur_q - 1'b1;
              end
            end else begin
              cur_q <= cur_q - 1'b1;
              if (cur_q == 8'd1) hit_q <= 1'b1;
              if (is_block) begin
                if (side_q) src_q <= init_q;
                else        dst_q <= init_q;
              end
            end
          end else begin
            state_q <= ST_XRD;
          end
        end

        ST_DWR: if (fin) begin
          if (idx_q == 2'd2) begin
            idx_q <= 2'd0;
            if (ctl_q.chain) begin
              dptr_q  <= dptr_q + xaddr_t'(DESC_BYTES);
              state_q <= ST_DRD;
            end else begin
              state_q <= ST_INT;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end

        ST_INT: if (fin) begin
          irq_q   <= hit_q;
          state_q <= ST_IDLE;
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evt_xfer_seq.sv
module evt_xfer_seq
  import evt_xfer_pkg::*;
#(
  parameter int          VEC_W       = 4,
  parameter int          CNT_W       = 16,
  parameter int          COST_MEM    = 1,
  parameter int          COST_IO_B   = 2,
  parameter int          COST_IO16_W = 2,
  parameter int          COST_IO8_W  = 4,
  parameter int          INT_N       = 3,
  parameter logic [15:0] VEC_BASE    = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [VEC_W-1:0]  evt_vec,
  output logic              busy,
  output logic [CNT_W-1:0]  state_cnt,
  output logic              done_irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int MAXC = (COST_IO8_W > COST_IO16_W ? COST_IO8_W : COST_IO16_W) * 2;
  localparam int CW   = $clog2(MAXC + 1) + 1;

  logic [CW-1:0] acc_cost;
  logic          start;

  evt_xfer_cost #(
    .COST_MEM   (COST_MEM),
    .COST_IO_B  (COST_IO_B),
    .COST_IO16_W(COST_IO16_W),
    .COST_IO8_W (COST_IO8_W),
    .CW         (CW)
  ) u_cost (
    .addr(mem_addr),
    .size(mem_size),
    .cost(acc_cost)
  );

  evt_xfer_ctrl #(
    .VEC_W   (VEC_W),
    .CW      (CW),
    .INT_N   (INT_N),
    .VEC_BASE(VEC_BASE)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_valid(evt_valid),
    .evt_vec  (evt_vec),
    .evt_ready(evt_ready),
    .start    (start),
    .busy     (busy),
    .done_irq (done_irq),
    .acc_cost (acc_cost),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_size (mem_size),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  evt_xfer_stcnt #(
    .CNT_W(CNT_W)
  ) u_stcnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .inc  (busy),
    .cnt  (state_cnt)
  );

endmodule

// File: rtl/evt_xfer_seq_chk.sv
module evt_xfer_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic             evt_ready,
  input logic             busy,
  input logic [CNT_W-1:0] state_cnt,
  input logic             done_irq,
  input logic             mem_req,
  input logic             mem_we,
  input logic [1:0]       mem_size
);

  // R1: acceptance starts the vector word read in the next cycle
  a_r1_start_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> (busy && mem_req && !mem_we && mem_size == 2'd1));

  // R1: no acceptance while an activation runs
  a_r1_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !evt_ready);

  // R4: bus accesses only happen inside an activation
  a_r4_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R10: each busy state adds one to the counter
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (state_cnt - $past(state_cnt)) == CNT_W'(1));

  // R10: idle without acceptance keeps the total
  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(evt_valid && evt_ready)) |=> $stable(state_cnt));

  // R11: interrupt only in the cycle busy drops
  a_r11_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $fell(busy));

endmodule

bind evt_xfer_seq evt_xfer_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_valid(evt_valid),
  .evt_ready(evt_ready),
  .busy     (busy),
  .state_cnt(state_cnt),
  .done_irq (done_irq),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_size (mem_size)
);

// File: tb/evt_xfer_seq_tb_top.sv
module evt_xfer_seq_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          WD_CYCLES  = 150000;
  localparam logic [15:0] DESC0      = 16'h40E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [3:0]  evt_vec = '0;
  logic        busy;
  logic [15:0] state_cnt;
  logic        done_irq;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  logic [7:0] mem [1024];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_vec(evt_vec), .busy(busy), .state_cnt(state_cnt), .done_irq(done_irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // model memory: 256 bytes in each of the four regions
  function automatic int bi(input logic [15:0] a);
    return int'({a[15:14], a[7:0]});
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  always_comb begin
    case (mem_size)
      2'd0:    mem_rdata = {24'h0, mem[bi(mem_addr)]};
      2'd1:    mem_rdata = {16'h0, mem[bi(mem_addr + 16'd1)], mem[bi(mem_addr)]};
      default: mem_rdata = {mem[bi(mem_addr + 16'd3)], mem[bi(mem_addr + 16'd2)],
                            mem[bi(mem_addr + 16'd1)], mem[bi(mem_addr)]};
    endcase
  end

  task automatic put32(input logic [15:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[bi(a + 16'(k))] = v[8*k +: 8];
  endtask

  task automatic bus_write();
    int nbytes;
    nbytes = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
    for (int k = 0; k < nbytes; k++) mem[bi(mem_addr + 16'(k))] = mem_wdata[8*k +: 8];
  endtask

  function automatic logic [15:0] get16(input logic [15:0] a);
    return {mem[bi(a + 16'd1)], mem[bi(a)]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cost(input int rg, input int sz);
    if (rg < 2) return 1;
    if (rg == 2) return 2;
    return sz ? 4 : 2;
  endfunction

  function automatic logic [1:0] code_of(input int x);
    return (x == 0) ? 2'b01 : (x == 1) ? 2'b10 : 2'b00;
  endfunction

  function automatic int delta(input logic [1:0] c, input int w);
    return (c == 2'b01) ? w : (c == 2'b10) ? -w : 0;
  endfunction

  task automatic run_case(input int m, input int sr, input int dr, input int sz, input int nch);
    logic [15:0] s0 [2];
    logic [15:0] d0 [2];
    logic [15:0] sE [2];
    logic [15:0] dE [2];
    logic [1:0]  sc [2];
    logic [1:0]  dc [2];
    int          pairs [2];
    int          cnt [2];
    int          ecnt [2];
    int          side [2];
    int          w, exp_st, nb, rdy_bad, vec;
    bit          exp_irq;
    string       mreq;
    w = sz ? 2 : 1;
    exp_irq = 0;
    mreq = (m == 0) ? "R5" : (m == 1) ? "R6" : "R7";
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    vec = (m + sr + dr) % 4;
    put32(16'(2 * vec), {16'h0, DESC0});
    exp_st = 1 + 3;
    for (int d = 0; d < nch; d++) begin
      logic [7:0]  ctl;
      logic [15:0] da;
      int          rel;
      s0[d] = 16'(sr << 14) + 16'h0020 + 16'(d * 16);
      d0[d] = 16'(dr << 14) + 16'h0080 + 16'(d * 32);
      sc[d] = code_of((m + d + sz) % 3);
      dc[d] = code_of((sr + d + dr) % 3);
      side[d] = (sr + d + sz) % 2;
      cnt[d] = ((d + dr + sz) % 2 == 1) ? 1 : 3;
      rel = 2 + d;
      pairs[d] = (m == 2) ? rel : 1;
      ctl = {2'(m), 1'(sz), sc[d], dc[d], 1'(d < nch - 1)};
      da = DESC0 + 16'(12 * d);
      put32(da, {s0[d], d0[d]});
      put32(da + 16'd4, {ctl, side[d] ? 8'h80 : 8'h00, 8'(rel), 8'(cnt[d])});
      put32(da + 16'd8, {16'h0, side[d] ? s0[d] : d0[d]});
      exp_st += 6 + pairs[d] * (cost(sr, sz) + cost(dr, sz));
      sE[d] = 16'(int'(s0[d]) + pairs[d] * delta(sc[d], w));
      dE[d] = 16'(int'(d0[d]) + pairs[d] * delta(dc[d], w));
      ecnt[d] = cnt[d] - 1;
      if (m == 2 || (m == 1 && cnt[d] == 1)) begin
        if (side[d] == 1) sE[d] = s0[d];
        else              dE[d] = d0[d];
      end
      if (m == 1 && cnt[d] == 1) ecnt[d] = rel;
      if (m != 1 && cnt[d] == 1) exp_irq = 1;
    end

    // offer the event in an idle cycle; it is taken on the next edge
    @(negedge clk);
    evt_vec   = 4'(vec);
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
    nb = 0;
    rdy_bad = 0;
    while (busy && nb < 1000) begin
      nb++;
      if (evt_ready) rdy_bad = 1;
      if (mem_req && mem_we) bus_write();
      @(negedge clk);
    end
    // first idle cycle: every result is due here
    chk(state_cnt == exp_st, "R4 R9 R10 state_cnt", int'(state_cnt), exp_st);
    chk(nb == exp_st, "R1 busy cycles", nb, exp_st);
    chk(rdy_bad == 0, "R1 evt_ready low while busy", rdy_bad, 0);
    chk(done_irq == exp_irq, {"R11 ", mreq, " done_irq"}, int'(done_irq), int'(exp_irq));
    for (int d = 0; d < nch; d++) begin
      logic [15:0] da;
      int          okd;
      da = DESC0 + 16'(12 * d);
      okd = 1;
      for (int p = 0; p < pairs[d]; p++) begin
        logic [15:0] sa, dA;
        if (dc[d] == 2'b00 && p < pairs[d] - 1) continue;
        sa = 16'(int'(s0[d]) + p * delta(sc[d], w));
        dA = 16'(int'(d0[d]) + p * delta(dc[d], w));
        for (int b = 0; b < w; b++)
          if (mem[bi(dA + 16'(b))] != pat(bi(sa + 16'(b)))) okd = 0;
      end
      chk(okd == 1, {"R2 R8 data ", mreq}, okd, 1);
      chk(get16(da + 16'd2) == sE[d], {"R3 R8 src writeback ", mreq},
          int'(get16(da + 16'd2)), int'(sE[d]));
      chk(get16(da) == dE[d], {"R3 R8 dst writeback ", mreq}, int'(get16(da)), int'(dE[d]));
      chk(mem[bi(da + 16'd4)] == 8'(ecnt[d]), {"R3 count writeback ", mreq},
          int'(mem[bi(da + 16'd4)]), ecnt[d] & 255);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0, "R12 busy", int'(busy), 0);
    chk(evt_ready == 1'b1, "R12 evt_ready", int'(evt_ready), 1);
    chk(state_cnt == 16'd0, "R12 state_cnt", int'(state_cnt), 0);
    chk(done_irq == 1'b0, "R12 done_irq", int'(done_irq), 0);
    chk(mem_req == 1'b0, "R12 mem_req", int'(mem_req), 0);
    for (int m = 0; m < 3; m++)
      for (int sr = 0; sr < 4; sr++)
        for (int dr = 1; dr < 4; dr++)
          for (int sz = 0; sz < 2; sz++)
            for (int nch = 1; nch <= 2; nch++)
              run_case(m, sr, dr, sz, nch);
    // counter keeps its total while idle
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && done_irq == 1'b0, "R10 R11 idle after run", int'(done_irq), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    $display("FAIL watchdog R1 actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad + 1);
    $finish;
  end

endmodule